// File: doc/BRIEF.md
# Parallel Memory Boot Width Detector

This block runs once after every reset and works out how the rest of a boot load is to be fetched from an asynchronous parallel memory. It samples a three-bit mode input on the first clock after reset is released. In parallel-boot mode it performs a single read at the bank base address 0x2000_0000, using the slowest bus timing a device could need. It then decodes the low byte of that read as a signature that selects the memory width and the DMA transfer size.

In bypass mode no memory is touched. The block reports at once that execution starts at the base address with 16-bit packing. An unknown signature raises an error and parks the block until the next reset. The DMA engine that later consumes the result, and the code that drives it, lie outside this block.

Top module: `pmem_boot_probe`

## Requirements
- R1: While reset is held, chip select, read strobe and write strobe are all high (inactive), done and error are 0, and the address and entry outputs are zero.
- R2: The mode is taken from `mode_i` on the first rising edge with `rst_n` high. Later changes of `mode_i` have no effect on the bus activity or on the result.
- R3: In mode 3'b001 the bus access starts on the first cycle after reset release. Chip select is low for exactly 4 + 15 + 3 = 22 consecutive cycles: 4 setup cycles with the read strobe high, then 15 cycles with the read strobe low, then 3 hold cycles with the read strobe high. The address is 0x2000_0000 whenever chip select is low, and the write strobe never goes low.
- R4: The signature byte is `mem_data_i[7:0]` as seen in the last of the 15 strobe cycles. Data on the bus in any other cycle has no effect on the result.
- R5: Signature 0x40 gives `res_width16_o`=0 and `res_dma16_o`=0 with `res_done_o`=1.
- R6: Signature 0x60 gives `res_width16_o`=1 and `res_dma16_o`=0 with `res_done_o`=1.
- R7: Signature 0x20 gives `res_width16_o`=1 and `res_dma16_o`=1 with `res_done_o`=1.
- R8: Any other signature sets `res_error_o`=1 and keeps `res_done_o`=0. No further bus access follows, and the error holds until reset.
- R9: In mode 3'b000 (bypass) chip select never goes low. One cycle after reset release, `res_done_o`=1, `res_width16_o`=1, `res_dma16_o`=0 and `res_exec_o`=1. In every other case `res_exec_o` is 0.
- R10: Any mode other than 3'b000 and 3'b001 leaves the bus idle, with done and error at 0.
- R11: After a valid signature, done rises in the cycle after the last hold cycle (23 cycles after reset release). From then until reset, done, the result fields and `res_entry_o` = 0x2000_0000 hold steady. `res_entry_o` is zero while done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| mode_i | input | 3 | Boot mode, sampled once after reset |
| mem_addr_o | output | 32 | Memory address, driven during an access |
| mem_data_i | input | 16 | Memory read data |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_rd_n_o | output | 1 | Read strobe, active low |
| mem_wr_n_o | output | 1 | Write strobe, active low (held inactive) |
| res_width16_o | output | 1 | 1: 16-bit memory, 0: 8-bit memory |
| res_dma16_o | output | 1 | 1: 16-bit DMA transfers, 0: 8-bit |
| res_exec_o | output | 1 | 1: execute in place (bypass) |
| res_entry_o | output | 32 | Start address once done |
| res_error_o | output | 1 | Unknown signature, sticky until reset |
| res_done_o | output | 1 | Result valid |

## Verification
The bench builds the block with its default timing of 4 setup, 15 strobe and 3 hold cycles. At these values the whole access fits in 22 cycles, so every cycle of every phase can be counted at the ports. The bench drives a fresh garbage byte on every strobe cycle except the last, which exposes any capture on the wrong cycle. The default 32-bit address and 16-bit data widths keep the real base address and the upper data lane in play, so an unused upper byte is seen to have no effect.

// File: rtl/pbp_pkg.sv
package pbp_pkg;

    localparam logic [2:0] MODE_BYPASS   = 3'b000;
    localparam logic [2:0] MODE_PARALLEL = 3'b001;

    localparam logic [7:0] SIG_W8_D8   = 8'h40;
    localparam logic [7:0] SIG_W16_D8  = 8'h60;
    localparam logic [7:0] SIG_W16_D16 = 8'h20;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    typedef enum logic [2:0] {
        CS_SAMPLE,
        CS_FETCH,
        CS_READY,
        CS_HALT,
        CS_OFF
    } ctl_state_e;

    typedef struct packed {
        logic width16;
        logic dma16;
        logic bad;
    } sig_info_t;

    typedef struct packed {
        ctl_state_e  state;
        logic [2:0]  mode;
        logic [7:0]  sig;
        logic        width16;
        logic        dma16;
        logic        exec;
        logic        err;
        logic        done;
    } ctl_t;

endpackage

// File: rtl/pbp_sig_decode.sv
module pbp_sig_decode
    import pbp_pkg::*;
(
    input  logic [7:0] sig_i,
    output sig_info_t  info_o
);

    always_comb begin
        info_o = '{width16: 1'b0, dma16: 1'b0, bad: 1'b0};
        case (sig_i)
            SIG_W8_D8:   info_o = '{width16: 1'b0, dma16: 1'b0, bad: 1'b0};
            SIG_W16_D8:  info_o = '{width16: 1'b1, dma16: 1'b0, bad: 1'b0};
            SIG_W16_D16: info_o = '{width16: 1'b1, dma16: 1'b1, bad: 1'b0};
            default:     info_o = '{width16: 1'b0, dma16: 1'b0, bad: 1'b1};
        endcase
    end

endmodule

// File: rtl/pbp_access_timer.sv
module pbp_access_timer
    import pbp_pkg::*;
#(
    parameter int SETUP_CYC  = 4,
    parameter int STROBE_CYC = 15,
    parameter int HOLD_CYC   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic strobe,
    output logic last_strobe,
    output logic last_hold
);

    localparam int MAX_SR  = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int MAX_CYC = (MAX_SR > HOLD_CYC) ? MAX_SR : HOLD_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] SETUP_END  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] STROBE_END = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_END   = CNT_W'(HOLD_CYC - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t             tmr_q, tmr_d;
    logic [CNT_W-1:0] end_cnt;

    always_comb begin
        case (tmr_q.phase)
            PH_SETUP:  end_cnt = SETUP_END;
            PH_STROBE: end_cnt = STROBE_END;
            default:   end_cnt = HOLD_END;
        endcase
    end

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.phase == PH_IDLE) begin
            if (start) begin
                tmr_d.phase = PH_SETUP;
                tmr_d.cnt   = '0;
            end
        end else if (tmr_q.cnt == end_cnt) begin
            tmr_d.cnt = '0;
            case (tmr_q.phase)
                PH_SETUP:  tmr_d.phase = PH_STROBE;
                PH_STROBE: tmr_d.phase = PH_HOLD;
                default:   tmr_d.phase = PH_IDLE;
            endcase
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '{phase: PH_IDLE, cnt: '0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy        = (tmr_q.phase != PH_IDLE);
    assign strobe      = (tmr_q.phase == PH_STROBE);
    assign last_strobe = strobe && (tmr_q.cnt == STROBE_END);
    assign last_hold   = (tmr_q.phase == PH_HOLD) && (tmr_q.cnt == HOLD_END);

    // R3: each phase runs for its full length before the next one begins
    a_r3_setup_len: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.phase == PH_STROBE && $past(tmr_q.phase) == PH_SETUP)
        |-> $past(tmr_q.cnt) == SETUP_END);

    a_r3_strobe_len: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.phase == PH_HOLD && $past(tmr_q.phase) == PH_STROBE)
        |-> $past(tmr_q.cnt) == STROBE_END);

    a_r3_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.phase == PH_IDLE && $past(tmr_q.phase) == PH_HOLD)
        |-> $past(tmr_q.cnt) == HOLD_END);

endmodule

// File: rtl/pmem_boot_probe.sv
module pmem_boot_probe
    import pbp_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 16,
    parameter logic [31:0] BASE_ADDR  = 32'h2000_0000,
    parameter int          SETUP_CYC  = 4,
    parameter int          STROBE_CYC = 15,
    parameter int          HOLD_CYC   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic              mem_cs_n_o,
    output logic              mem_rd_n_o,
    output logic              mem_wr_n_o,
    output logic              res_width16_o,
    output logic              res_dma16_o,
    output logic              res_exec_o,
    output logic [ADDR_W-1:0] res_entry_o,
    output logic              res_error_o,
    output logic              res_done_o
);

    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

    ctl_t      ctl_q, ctl_d;
    logic      tmr_start;
    logic      tmr_busy, tmr_strobe, tmr_last_strobe, tmr_last_hold;
    sig_info_t sig_info;
    logic      unused_hi;

    assign unused_hi = ^mem_data_i[DATA_W-1:8];

    pbp_access_timer #(
        .SETUP_CYC  (SETUP_CYC),
        .STROBE_CYC (STROBE_CYC),
        .HOLD_CYC   (HOLD_CYC)
    ) i_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (tmr_start),
        .busy        (tmr_busy),
        .strobe      (tmr_strobe),
        .last_strobe (tmr_last_strobe),
        .last_hold   (tmr_last_hold)
    );

    pbp_sig_decode i_decode (
        .sig_i  (ctl_q.sig),
        .info_o (sig_info)
    );

    always_comb begin
        ctl_d     = ctl_q;
        tmr_start = 1'b0;
        case (ctl_q.state)
            CS_SAMPLE: begin
                ctl_d.mode = mode_i;
                if (mode_i == MODE_BYPASS) begin
                    ctl_d.state   = CS_READY;
                    ctl_d.done    = 1'b1;
                    ctl_d.width16 = 1'b1;
                    ctl_d.exec    = 1'b1;
                end else if (mode_i == MODE_PARALLEL) begin
                    ctl_d.state = CS_FETCH;
                    tmr_start   = 1'b1;
                end else begin
                    ctl_d.state = CS_OFF;
                end
            end
            CS_FETCH: begin
                if (tmr_last_strobe) begin
                    ctl_d.sig = mem_data_i[7:0];
                end
                if (tmr_last_hold) begin
                    if (sig_info.bad) begin
                        ctl_d.state = CS_HALT;
                        ctl_d.err   = 1'b1;
                    end else begin
                        ctl_d.state   = CS_READY;
                        ctl_d.done    = 1'b1;
                        ctl_d.width16 = sig_info.width16;
                        ctl_d.dma16   = sig_info.dma16;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: CS_SAMPLE, mode: 3'b000, sig: 8'h00,
                       width16: 1'b0, dma16: 1'b0, exec: 1'b0,
                       err: 1'b0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mem_cs_n_o    = !tmr_busy;
    assign mem_rd_n_o    = !tmr_strobe;
    assign mem_wr_n_o    = 1'b1;
    assign mem_addr_o    = tmr_busy ? BASE : '0;
    assign res_width16_o = ctl_q.width16;
    assign res_dma16_o   = ctl_q.dma16;
    assign res_exec_o    = ctl_q.exec;
    assign res_error_o   = ctl_q.err;
    assign res_done_o    = ctl_q.done;
    assign res_entry_o   = ctl_q.done ? BASE : '0;

    // R3: read strobe only inside an active chip select
    a_r3_rd_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n_o |-> !mem_cs_n_o);

    // R2: the sampled mode never changes after the first cycle
    a_r2_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state != CS_SAMPLE) |=> $stable(ctl_q.mode));

    // R8: halt is sticky, flagged and quiet
    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == CS_HALT) |=> (ctl_q.state == CS_HALT && res_error_o && mem_cs_n_o));

    // R8: error and done never both set
    a_r8_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_done_o && res_error_o));

    // R9: bypass never touches the bus
    a_r9_bypass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state != CS_SAMPLE && ctl_q.mode == MODE_BYPASS) |-> mem_cs_n_o);

    // R11: results hold once done
    a_r11_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        res_done_o |=> (res_done_o && $stable(res_width16_o) && $stable(res_dma16_o)
                        && $stable(res_exec_o) && mem_cs_n_o));

endmodule

// File: tb/test_pmem_boot_probe.sv
module test_pmem_boot_probe;

    localparam logic [31:0] BASE = 32'h2000_0000;
    localparam int S = 4;
    localparam int T = 15;
    localparam int H = 3;
    localparam int ACC = S + T + H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_i = 3'b000;
    logic [15:0] mem_data_i = 16'h0;
    logic [31:0] mem_addr_o, res_entry_o;
    logic        mem_cs_n_o, mem_rd_n_o, mem_wr_n_o;
    logic        res_width16_o, res_dma16_o, res_exec_o, res_error_o, res_done_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pmem_boot_probe i_pmem_boot_probe (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode_i),
        .mem_addr_o    (mem_addr_o),
        .mem_data_i    (mem_data_i),
        .mem_cs_n_o    (mem_cs_n_o),
        .mem_rd_n_o    (mem_rd_n_o),
        .mem_wr_n_o    (mem_wr_n_o),
        .res_width16_o (res_width16_o),
        .res_dma16_o   (res_dma16_o),
        .res_exec_o    (res_exec_o),
        .res_entry_o   (res_entry_o),
        .res_error_o   (res_error_o),
        .res_done_o    (res_done_o)
    );

    typedef struct packed {
        bit done;
        bit err;
        bit w16;
        bit d16;
        bit exe;
        bit bus;
    } exp_t;

    function automatic exp_t expect_of(input logic [2:0] m, input logic [7:0] s);
        exp_t e = '0;
        if (m == 3'b000) begin
            e.done = 1; e.w16 = 1; e.exe = 1;
        end else if (m == 3'b001) begin
            e.bus = 1;
            case (s)
                8'h40:   e.done = 1;
                8'h60:   begin e.done = 1; e.w16 = 1; end
                8'h20:   begin e.done = 1; e.w16 = 1; e.d16 = 1; end
                default: e.err = 1;
            endcase
        end
        return e;
    endfunction

    function automatic string tag_of(input logic [2:0] m, input logic [7:0] s);
        if (m == 3'b000) return "R9";
        if (m != 3'b001) return "R10";
        case (s)
            8'h40:   return "R5";
            8'h60:   return "R6";
            8'h20:   return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_case(input logic [2:0] m, input logic [7:0] sig,
                            input bit scramble, input string tag);
        int setup_n = 0, strobe_n = 0, hold_n = 0, cs_tot = 0;
        int bad_addr = 0, wr_bad = 0, done_at = -1, err_at = -1;
        exp_t e;
        rst_n  = 1'b0;
        mode_i = m;
        mem_data_i = 16'($urandom);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1", {mem_cs_n_o, mem_rd_n_o, mem_wr_n_o}, 3'b111);
        check_eq("R1", {res_done_o, res_error_o}, 2'b00);
        check_eq("R1", {mem_addr_o, res_entry_o}, 64'h0);
        rst_n = 1'b1;
        for (int k = 1; k <= 45; k++) begin
            @(negedge clk);
            if (scramble) mode_i = 3'($urandom);
            if (!mem_cs_n_o) begin
                cs_tot++;
                if (mem_addr_o !== BASE) bad_addr++;
                if (!mem_rd_n_o) strobe_n++;
                else if (strobe_n == 0) setup_n++;
                else hold_n++;
            end else if (!mem_rd_n_o) begin
                bad_addr++;
            end
            if (!mem_wr_n_o) wr_bad++;
            if (res_done_o && done_at < 0) done_at = k;
            if (res_error_o && err_at < 0) err_at = k;
            if (!mem_rd_n_o && strobe_n == T)
                mem_data_i = {8'($urandom), sig};
            else
                mem_data_i = {8'($urandom), sig ^ (8'($urandom) | 8'h01)};
        end
        e = expect_of(m, sig);
        if (e.bus) begin
            check_eq("R3", 64'(setup_n), 64'(S));
            check_eq("R3", 64'(strobe_n), 64'(T));
            check_eq("R3", 64'(hold_n), 64'(H));
            check_eq(e.err ? "R8" : "R3", 64'(cs_tot), 64'(ACC));
        end else begin
            check_eq(tag, 64'(cs_tot), 64'(0));
        end
        check_eq("R3", 64'(bad_addr), 64'(0));
        check_eq("R3", 64'(wr_bad), 64'(0));
        check_eq(tag, {res_done_o, res_error_o, res_width16_o, res_dma16_o, res_exec_o},
                 {e.done, e.err, e.w16, e.d16, e.exe});
        check_eq("R11", res_entry_o, e.done ? BASE : 32'h0);
        if (m == 3'b000)
            check_eq("R9", 64'(done_at), 64'(1));
        else if (e.done)
            check_eq("R11", 64'(done_at), 64'(ACC + 1));
        else
            check_eq(tag, 64'(done_at), 64'(-1));
        check_eq(tag, 64'(err_at), e.err ? 64'(ACC + 1) : 64'(-1));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stimulus
        int seed_dummy;
        seed_dummy = $urandom(32'hB007);
        // directed corner cases
        run_case(3'b001, 8'h40, 1'b0, "R5");
        run_case(3'b001, 8'h60, 1'b0, "R6");
        run_case(3'b001, 8'h20, 1'b0, "R7");
        run_case(3'b001, 8'h41, 1'b0, "R8");
        run_case(3'b001, 8'h00, 1'b0, "R8");
        run_case(3'b000, 8'h20, 1'b0, "R9");
        run_case(3'b011, 8'h40, 1'b0, "R10");
        run_case(3'b111, 8'h20, 1'b0, "R10");
        run_case(3'b001, 8'h20, 1'b1, "R2");
        run_case(3'b000, 8'h60, 1'b1, "R2");
        run_case(3'b001, 8'h60, 1'b0, "R4");
        // constrained random
        for (int i = 0; i < 30; i++) begin
            logic [2:0] m;
            logic [7:0] s;
            int r = $urandom % 8;
            m = (r < 4) ? 3'b001 : (r < 6) ? 3'b000 : 3'(2 + ($urandom % 6));
            case ($urandom % 4)
                0: s = 8'h40;
                1: s = 8'h60;
                2: s = 8'h20;
                default: s = 8'($urandom);
            endcase
            run_case(m, s, 1'($urandom), tag_of(m, s));
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule